// File: doc/BRIEF.md
# SDRAM Host Access Adapter

This block connects a simple SRAM-style host bus to the command sequencer of a controller for 32-bit-wide SDRAM. The host starts a single read or write by pulling its active-low select low together with an active-low read or write strobe. It supplies a 23-bit byte address and a 2-bit size code. The adapter latches the request, raises a level request toward the sequencer and holds the host in a wait state through an active-low busy output until the sequencer acknowledges. Only one transfer is in flight at any time, and bursts are not supported.

On the memory side the adapter splits the byte address into bank, row and column. It places byte and half-word data on the correct 32-bit lanes and produces an active-high per-lane mask. For reads it returns the selected lanes to the host. The `ALIGN_LOW` parameter chooses how narrow data sits on the host bus. When it is set, narrow data travels on the low-order host lanes. When it is clear, narrow data stays on its natural lanes. A write made while the active-low mode-set input is low becomes a mode-register programming request. That request carries the low 11 bits of the write data on the row output.

Top module: `sdram_host_adapter`

## Requirements
- R1: After reset, `host_busy_n` is 1, `seq_req` is 0 and `host_rdata` is 0.
- R2: When `host_cs_n` is 0 with `host_rd_n` or `host_wr_n` at 0 in the idle state, `host_busy_n` is 0 and `seq_req` is 1 after the next clock edge, and `seq_write` equals 1 for a write strobe. If both strobes are low, the write wins. A strobe seen while `host_cs_n` is 1 has no effect.
- R3: `host_busy_n` stays 0 and `seq_req` stays 1 until a clock edge samples `seq_ack` at 1.
- R4: After the edge that samples `seq_ack` at 1, `host_busy_n` is 1 and `seq_req` is 0. For a read, `host_rdata` holds the steered read data from that same edge.
- R5: After busy is released, no new access starts until a clock edge finds select high or both strobes high. A strobe held low keeps `host_busy_n` at 1.
- R6: For memory accesses, `mem_bank` = address[22:21], `mem_row` = address[20:10] and `mem_col` = address[9:2].
- R7: `mem_mask` bit i is 1 when lane i (data bits 8i+7..8i) is not accessed. Size code 1 (byte) enables only lane address[1:0]. Size code 2 (half-word) enables lanes 0–1 when address[1] is 0 and lanes 2–3 when it is 1. Size code 0 (word) enables all four lanes.
- R8: With `ALIGN_LOW`=1, write data for a byte or half-word is taken from the low host lanes and shifted onto the enabled memory lanes. Lanes that are not enabled are 0.
- R9: With `ALIGN_LOW`=1, read data from the enabled memory lanes is shifted down to host lane 0, and the upper host lanes are 0.
- R10: With `ALIGN_LOW`=0, write and read data keep their natural lanes, with all lanes that are not enabled set to 0.
- R11: Size code 3 behaves exactly like size code 0 (word).
- R12: A write with `host_mset_n` at 0 produces `seq_mode`=1, `seq_write`=1, `mem_row`=write data[10:0], `mem_bank`=0, `mem_col`=0 and `mem_mask`=4'hF. A read with `host_mset_n` at 0 is an ordinary read with `seq_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_mset_n | input | 1 | Mode-register programming select, active low |
| host_size | input | 2 | Transfer size: 0 word, 1 byte, 2 half-word, 3 word |
| host_addr | input | 23 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data to host |
| host_busy_n | output | 1 | Wait request to host, active low |
| seq_req | output | 1 | Request to sequencer, held until acknowledged |
| seq_write | output | 1 | Request is a write |
| seq_mode | output | 1 | Request is a mode-register write |
| seq_ack | input | 1 | Sequencer completion pulse |
| mem_bank | output | 2 | Bank select |
| mem_row | output | 11 | Row address, or mode value |
| mem_col | output | 8 | Column address |
| mem_mask | output | 4 | Per-lane mask, 1 = lane not accessed |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read data from memory, valid with `seq_ack` |

## Verification
The hardest case to reach is the window after busy is released while the host still holds its strobe low. In that window a careless design would start a second access from a request that has already been served. The stimulus reaches it by holding the strobe and select low for several cycles after the acknowledge. It checks busy on each of those cycles and only then releases the bus. A second copy of the block with natural-lane placement receives the same stimulus. This lets a single sequence of byte and half-word accesses on every lane cover both steering modes.

// File: rtl/sha_pkg.sv
package sha_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } sha_state_e;

    // Size encoding seen on the host bus; code 3 falls into the word branch.
    localparam logic [1:0] SZ_WORD = 2'd0;
    localparam logic [1:0] SZ_BYTE = 2'd1;
    localparam logic [1:0] SZ_HALF = 2'd2;

endpackage

// File: rtl/sha_addr_split.sv
module sha_addr_split #(
    parameter int LANE_W = 2,
    parameter int COL_W  = 8,
    parameter int ROW_W  = 11,
    parameter int BANK_W = 2,
    localparam int ADDR_W = LANE_W + COL_W + ROW_W + BANK_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LANE_W-1:0] lane,
    output logic [COL_W-1:0]  col,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank
);
    assign lane = addr[LANE_W-1:0];
    assign col  = addr[LANE_W +: COL_W];
    assign row  = addr[LANE_W+COL_W +: ROW_W];
    assign bank = addr[ADDR_W-1 -: BANK_W];
endmodule

// File: rtl/sha_lane_sel.sv
module sha_lane_sel
    import sha_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 2
) (
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    output logic [LANE_W-1:0] off,
    output logic [LANES-1:0]  en
);
    logic [LANE_W:0] nbytes;

    always_comb begin
        case (size)
            SZ_BYTE: begin
                off    = lane;
                nbytes = (LANE_W+1)'(1);
            end
            SZ_HALF: begin
                off    = {lane[LANE_W-1:1], 1'b0};
                nbytes = (LANE_W+1)'(2);
            end
            default: begin
                off    = '0;
                nbytes = (LANE_W+1)'(LANES);
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_en
        assign en[g] = (32'(g) >= 32'(off)) && (32'(g) < 32'(off) + 32'(nbytes));
    end
endmodule

// File: rtl/sha_lane_steer.sv
module sha_lane_steer #(
    parameter int DATA_W    = 32,
    parameter int LANES     = 4,
    parameter int LANE_W    = 2,
    parameter bit ALIGN_LOW = 1'b1,
    parameter bit TO_MEM    = 1'b1
) (
    input  logic [DATA_W-1:0] din,
    input  logic [LANE_W-1:0] off,
    input  logic [LANES-1:0]  en,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0]   bitmask;
    logic [LANE_W+2:0]   shamt;

    assign shamt = {off, 3'b000};

    for (genvar g = 0; g < LANES; g++) begin : g_bm
        assign bitmask[g*8 +: 8] = {8{en[g]}};
    end

    if (!ALIGN_LOW) begin : g_natural
        assign dout = din & bitmask;
    end else if (TO_MEM) begin : g_align_wr
        assign dout = (din << shamt) & bitmask;
    end else begin : g_align_rd
        assign dout = (din & bitmask) >> shamt;
    end
endmodule

// File: rtl/sdram_host_adapter.sv
module sdram_host_adapter
    import sha_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int COL_W     = 8,
    parameter int ROW_W     = 11,
    parameter int BANK_W    = 2,
    parameter bit ALIGN_LOW = 1'b1,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int ADDR_W = LANE_W + COL_W + ROW_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_mset_n,
    input  logic [1:0]        host_size,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_busy_n,
    output logic              seq_req,
    output logic              seq_write,
    output logic              seq_mode,
    input  logic              seq_ack,
    output logic [BANK_W-1:0] mem_bank,
    output logic [ROW_W-1:0]  mem_row,
    output logic [COL_W-1:0]  mem_col,
    output logic [LANES-1:0]  mem_mask,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        sha_state_e          st;
        logic                busy_n;
        logic                req;
        logic                write;
        logic                mode;
        logic [1:0]          size;
        logic [LANE_W-1:0]   lane;
        logic [BANK_W-1:0]   bank;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic [LANES-1:0]    mask;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [LANE_W-1:0] a_lane;
    logic [COL_W-1:0]  a_col;
    logic [ROW_W-1:0]  a_row;
    logic [BANK_W-1:0] a_bank;
    logic [LANE_W-1:0] wr_off, rd_off;
    logic [LANES-1:0]  wr_en, rd_en;
    logic [DATA_W-1:0] wr_steered, rd_steered;
    logic              strobe;

    sha_addr_split #(
        .LANE_W(LANE_W), .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W)
    ) u_split (
        .addr(host_addr), .lane(a_lane), .col(a_col), .row(a_row), .bank(a_bank)
    );

    // Live selection for the request being accepted.
    sha_lane_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_sel_wr (
        .size(host_size), .lane(a_lane), .off(wr_off), .en(wr_en)
    );

    // Latched selection for returning read data.
    sha_lane_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_sel_rd (
        .size(r_q.size), .lane(r_q.lane), .off(rd_off), .en(rd_en)
    );

    sha_lane_steer #(
        .DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W),
        .ALIGN_LOW(ALIGN_LOW), .TO_MEM(1'b1)
    ) u_steer_wr (
        .din(host_wdata), .off(wr_off), .en(wr_en), .dout(wr_steered)
    );

    sha_lane_steer #(
        .DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W),
        .ALIGN_LOW(ALIGN_LOW), .TO_MEM(1'b0)
    ) u_steer_rd (
        .din(mem_rdata), .off(rd_off), .en(rd_en), .dout(rd_steered)
    );

    assign strobe = !host_cs_n && (!host_rd_n || !host_wr_n);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (strobe) begin
                    r_d.st     = ST_ACTIVE;
                    r_d.busy_n = 1'b0;
                    r_d.req    = 1'b1;
                    r_d.write  = !host_wr_n;
                    r_d.mode   = !host_wr_n && !host_mset_n;
                    r_d.size   = host_size;
                    r_d.lane   = a_lane;
                    if (!host_wr_n && !host_mset_n) begin
                        r_d.bank  = '0;
                        r_d.row   = host_wdata[ROW_W-1:0];
                        r_d.col   = '0;
                        r_d.mask  = '1;
                        r_d.wdata = '0;
                    end else begin
                        r_d.bank  = a_bank;
                        r_d.row   = a_row;
                        r_d.col   = a_col;
                        r_d.mask  = ~wr_en;
                        r_d.wdata = wr_steered;
                    end
                end
            end
            ST_ACTIVE: begin
                if (seq_ack) begin
                    r_d.st     = ST_HOLD;
                    r_d.busy_n = 1'b1;
                    r_d.req    = 1'b0;
                    if (!r_q.write) begin
                        r_d.rdata = rd_steered;
                    end
                end
            end
            default: begin
                if (!strobe) begin
                    r_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.busy_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_rdata  = r_q.rdata;
    assign host_busy_n = r_q.busy_n;
    assign seq_req     = r_q.req;
    assign seq_write   = r_q.write;
    assign seq_mode    = r_q.mode;
    assign mem_bank    = r_q.bank;
    assign mem_row     = r_q.row;
    assign mem_col     = r_q.col;
    assign mem_mask    = r_q.mask;
    assign mem_wdata   = r_q.wdata;
endmodule

// File: rtl/sha_checker.sv
module sha_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_cs_n,
    input logic             host_rd_n,
    input logic             host_wr_n,
    input logic [1:0]       host_size,
    input logic             host_busy_n,
    input logic             seq_req,
    input logic             seq_write,
    input logic             seq_mode,
    input logic             seq_ack,
    input logic [LANES-1:0] mem_mask
);
    p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req |-> !host_busy_n);

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req && !seq_ack |=> seq_req);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req && seq_ack |=> host_busy_n && !seq_req);

    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_busy_n) && !host_cs_n && (!host_rd_n || !host_wr_n) |=> host_busy_n);

    p_byte_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req && seq_write && !seq_mode && host_size == 2'd1
        |-> $countones(mem_mask) == LANES - 1);

    p_wide_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req && seq_write && !seq_mode && host_size == 2'd3 |-> mem_mask == '0);

    p_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req && seq_mode |-> seq_write && (&mem_mask));
endmodule

bind sdram_host_adapter sha_checker #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_size(host_size), .host_busy_n(host_busy_n),
    .seq_req(seq_req), .seq_write(seq_write), .seq_mode(seq_mode),
    .seq_ack(seq_ack), .mem_mask(mem_mask)
);

// File: tb/tb_sdram_host_adapter.sv
module tb_sdram_host_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mset_n = 1'b1;
    logic [1:0]  size = 2'd0;
    logic [22:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ack = 1'b0;
    logic [31:0] mrd = '0;

    logic [31:0] rdata [2];
    logic        busy_n [2], req [2], swr [2], smode [2];
    logic [1:0]  bank [2];
    logic [10:0] row [2];
    logic [7:0]  col [2];
    logic [3:0]  mask [2];
    logic [31:0] mwd [2];

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdram_host_adapter #(.ALIGN_LOW(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_mset_n(mset_n), .host_size(size), .host_addr(addr), .host_wdata(wdata),
        .host_rdata(rdata[0]), .host_busy_n(busy_n[0]), .seq_req(req[0]),
        .seq_write(swr[0]), .seq_mode(smode[0]), .seq_ack(ack), .mem_bank(bank[0]),
        .mem_row(row[0]), .mem_col(col[0]), .mem_mask(mask[0]), .mem_wdata(mwd[0]),
        .mem_rdata(mrd)
    );

    sdram_host_adapter #(.ALIGN_LOW(1'b0)) dut_nat (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_mset_n(mset_n), .host_size(size), .host_addr(addr), .host_wdata(wdata),
        .host_rdata(rdata[1]), .host_busy_n(busy_n[1]), .seq_req(req[1]),
        .seq_write(swr[1]), .seq_mode(smode[1]), .seq_ack(ack), .mem_bank(bank[1]),
        .mem_row(row[1]), .mem_col(col[1]), .mem_mask(mask[1]), .mem_wdata(mwd[1]),
        .mem_rdata(mrd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---- requirement-level helper functions ----
    function automatic int span_off(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd1) return int'(lo);
        if (sz == 2'd2) return lo[1] ? 2 : 0;
        return 0;
    endfunction

    function automatic int span_len(input logic [1:0] sz);
        if (sz == 2'd1) return 1;
        if (sz == 2'd2) return 2;
        return 4;
    endfunction

    function automatic logic [3:0] mask_of(input logic [1:0] sz, input logic [1:0] lo);
        int o = span_off(sz, lo);
        int n = span_len(sz);
        for (int i = 0; i < 4; i++) mask_of[i] = !(i >= o && i < o + n);
    endfunction

    function automatic logic [31:0] wr_steer(input bit al, input logic [1:0] sz,
                                             input logic [1:0] lo, input logic [31:0] d);
        int o = span_off(sz, lo);
        int n = span_len(sz);
        wr_steer = '0;
        for (int i = o; i < o + n; i++)
            wr_steer[i*8 +: 8] = al ? d[(i-o)*8 +: 8] : d[i*8 +: 8];
    endfunction

    function automatic logic [31:0] rd_steer(input bit al, input logic [1:0] sz,
                                             input logic [1:0] lo, input logic [31:0] d);
        int o = span_off(sz, lo);
        int n = span_len(sz);
        rd_steer = '0;
        for (int j = 0; j < n; j++) begin
            if (al) rd_steer[j*8 +: 8] = d[(o+j)*8 +: 8];
            else    rd_steer[(o+j)*8 +: 8] = d[(o+j)*8 +: 8];
        end
    endfunction

    // ---- cycle-by-cycle reference model ----
    int          ph = 0;
    logic        e_busy = 1'b1, e_req = 1'b0, e_wr = 1'b0, e_mode = 1'b0;
    logic [1:0]  e_bank = '0, r_sz = '0;
    logic [10:0] e_row = '0;
    logic [7:0]  e_col = '0;
    logic [3:0]  e_mask = '0;
    logic [22:0] r_a = '0;
    logic [31:0] e_wd [2] = '{32'h0, 32'h0};
    logic [31:0] e_rd [2] = '{32'h0, 32'h0};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= 0; e_busy <= 1'b1; e_req <= 1'b0; e_wr <= 1'b0; e_mode <= 1'b0;
            e_bank <= '0; e_row <= '0; e_col <= '0; e_mask <= '0; r_sz <= '0; r_a <= '0;
            e_wd[0] <= '0; e_wd[1] <= '0; e_rd[0] <= '0; e_rd[1] <= '0;
        end else begin
            case (ph)
                0: if (!cs_n && (!rd_n || !wr_n)) begin
                    ph <= 1; e_busy <= 1'b0; e_req <= 1'b1;
                    e_wr <= !wr_n; e_mode <= !wr_n && !mset_n;
                    r_sz <= size; r_a <= addr;
                    if (!wr_n && !mset_n) begin
                        e_bank <= '0; e_row <= wdata[10:0]; e_col <= '0; e_mask <= 4'hF;
                        e_wd[0] <= '0; e_wd[1] <= '0;
                    end else begin
                        e_bank <= addr[22:21]; e_row <= addr[20:10]; e_col <= addr[9:2];
                        e_mask <= mask_of(size, addr[1:0]);
                        e_wd[0] <= wr_steer(1'b1, size, addr[1:0], wdata);
                        e_wd[1] <= wr_steer(1'b0, size, addr[1:0], wdata);
                    end
                end
                1: if (ack) begin
                    ph <= 2; e_busy <= 1'b1; e_req <= 1'b0;
                    if (!e_wr) begin
                        e_rd[0] <= rd_steer(1'b1, r_sz, r_a[1:0], mrd);
                        e_rd[1] <= rd_steer(1'b0, r_sz, r_a[1:0], mrd);
                    end
                end
                default: if (!(!cs_n && (!rd_n || !wr_n))) ph <= 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int k = 0; k < 2; k++) begin
                chk("R3 busy", 32'(busy_n[k]), 32'(e_busy));
                chk("R3 req", 32'(req[k]), 32'(e_req));
                chk("R2 write", 32'(swr[k]), 32'(e_wr));
                chk("R12 mode", 32'(smode[k]), 32'(e_mode));
                chk("R6 bank", 32'(bank[k]), 32'(e_bank));
                chk("R6 row", 32'(row[k]), 32'(e_row));
                chk("R6 col", 32'(col[k]), 32'(e_col));
                chk(r_sz == 2'd3 ? "R11 mask" : "R7 mask", 32'(mask[k]), 32'(e_mask));
                chk(k == 0 ? "R8 wdata" : "R10 wdata", mwd[k], e_wd[k]);
                chk(k == 0 ? "R9 rdata" : "R10 rdata", rdata[k], e_rd[k]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R3 watchdog actual=%0d cycles expected=fewer", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic access(input bit is_wr, input logic [1:0] sz, input logic [22:0] a,
                          input logic [31:0] wd, input bit ms_n, input int dly,
                          input int hold, input logic [31:0] rdv);
        int guard = 0;
        @(negedge clk);
        cs_n = 1'b0; size = sz; addr = a; wdata = wd; mset_n = ms_n;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        while (busy_n[0] !== 1'b0 && guard < 20) begin @(negedge clk); guard++; end
        chk("R2 accept", 32'(busy_n[0]), 32'd0);
        repeat (dly) @(negedge clk);
        ack = 1'b1; mrd = rdv;
        @(negedge clk);
        ack = 1'b0; mrd = 32'h0;
        chk("R4 release", 32'(busy_n[0]), 32'd1);
        if (!is_wr) begin
            chk("R4 rdata", rdata[0], rd_steer(1'b1, sz, a[1:0], rdv));
            chk("R4 rdata nat", rdata[1], rd_steer(1'b0, sz, a[1:0], rdv));
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R5 held strobe", 32'(busy_n[0]), 32'd1);
            chk("R5 held req", 32'(req[0]), 32'd0);
        end
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; mset_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy_n[0]), 32'd1);
        chk("R1 req", 32'(req[0]), 32'd0);
        chk("R1 rdata", rdata[0], 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: strobe without select is ignored
        wr_n = 1'b0; rd_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R2 no select", 32'(busy_n[0]), 32'd1);
        end
        wr_n = 1'b1; rd_n = 1'b1;

        access(1, 2'd0, 23'h6B3A5C, 32'hDEADBEEF, 1, 2, 0, 32'h0);
        for (int l = 0; l < 4; l++)
            access(1, 2'd1, 23'h12340 + 23'(l), 32'h1122_33A5 + 32'(l), 1, l, 0, 32'h0);
        access(1, 2'd2, 23'h0F000, 32'hCAFE_BABE, 1, 1, 0, 32'h0);
        access(1, 2'd2, 23'h0F003, 32'h1357_9BDF, 1, 0, 0, 32'h0);
        access(1, 2'd3, 23'h7FFFFD, 32'hA5A5_5A5A, 1, 3, 0, 32'h0);   // R11
        access(0, 2'd0, 23'h200004, 32'h0, 1, 1, 0, 32'h8899_AABB);
        for (int l = 0; l < 4; l++)
            access(0, 2'd1, 23'h7FFFFC + 23'(l), 32'h0, 1, 0, 0, 32'hF1E2_D3C4);
        access(0, 2'd2, 23'h3C002, 32'h0, 1, 2, 0, 32'h0BAD_F00D);
        access(0, 2'd2, 23'h3C001, 32'h0, 1, 4, 0, 32'h7654_3210);
        access(0, 2'd3, 23'h555555, 32'h0, 1, 1, 0, 32'h0102_0304);   // R11
        access(1, 2'd0, 23'h1ABCDE, 32'hFFFF_F433, 0, 2, 0, 32'h0);   // R12 mode write
        access(0, 2'd1, 23'h1ABCDE, 32'h0, 0, 1, 0, 32'h9A00_0000);   // R12 read ignores mode-set
        access(1, 2'd1, 23'h000001, 32'h0000_0077, 1, 1, 4, 32'h0);   // R5
        access(0, 2'd0, 23'h000008, 32'h0, 1, 0, 3, 32'h3333_4444);   // R5
        // both strobes low: write wins (R2)
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; size = 2'd0; addr = 23'h040404;
        @(negedge clk);
        chk("R2 write wins", 32'(swr[0]), 32'd1);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule